// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

This block is a 16-bit down-counter that free-runs at the core clock, with two capture channels. Each channel watches one input pin. When the pin shows the edge that software has selected, the counter value is copied into that channel's capture register, and the channel's pending flag is set. The counter does not stop and does not reload. When the counter wraps from zero it sets a third pending flag. The two pins are sampled through a two-flop synchronizer, and edges are found by comparing consecutive synchronized samples.

Two interrupt lines leave the block. Line A combines the channel A capture and the counter wrap under a single enable bit, so software must inspect both pending flags to learn which event, or both, raised it. Line B carries channel B alone. In a second mode, pin A stops capturing and clocks the counter instead, one step per rising edge. Pin B then acts as a plain rising-edge interrupt input.

Software uses a small port: one write strobe with a 2-bit address, and a combinational read mux with its own address. Through it software loads the control word, clears flags and reads the two capture values.

Top module: `dual_capture_timer`

## Requirements
- R1: After synchronous reset, the counter holds 0xFFFF. Control, pending flags and both capture registers read 0, and both interrupt outputs are low.
- R2: In capture mode the counter decrements on every clock. When it steps from 0x0000 it wraps to 0xFFFF and sets the wrap flag (flag word bit 2) in that same step.
- R3: A selected edge on a pin is seen after two synchronizer flops. The resulting trigger lasts exactly one cycle and loads that channel's capture register with the counter value present in that cycle. The counter keeps running.
- R4: Control bit 1 selects the edge for pin A and control bit 2 selects it for pin B (0 = rising, 1 = falling). Each pin is set independently, and the edge not selected neither captures nor sets a flag.
- R5: A channel A trigger sets flag bit 0 and a channel B trigger sets flag bit 1. A set flag stays set until software writes address 1 with a 0 in that bit position. Writing a 1 leaves the flag unchanged. When a set and a clear land in the same cycle, the set wins.
- R6: irq_a equals control bit 3 AND (flag bit 0 OR flag bit 2). irq_b equals control bit 4 AND flag bit 1.
- R7: With control bit 0 = 1 (event mode), the counter steps only once per synchronized rising edge on pin A. Pin A then neither captures nor sets flag bit 0.
- R8: In event mode, a synchronized rising edge on pin B sets flag bit 1 whatever control bit 2 holds, and capture register B does not load.
- R9: Read address 0 returns the 5-bit control word, address 1 returns the 3-bit flag word, and addresses 2 and 3 return capture A and capture B. Unused upper bits read 0. Writes to address 0 replace the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Asynchronous channel A input (event clock in event mode) |
| pin_b | input | 1 | Asynchronous channel B input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 flag clear |
| wr_data | input | 5 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| irq_a | output | 1 | Channel A capture or counter wrap interrupt |
| irq_b | output | 1 | Channel B interrupt |

## Verification
The bench drives a flag clear in exactly the cycle in which a trigger sets the same flag. A design that lets the clear win would lose that capture event. It checks each pin against the edge it did not select, which exposes polarity bits that are swapped or shared between the pins. It lets the counter run through a full wrap, where a missing wrap flag or an unshared enable shows up on irq_a. In event mode it checks that pin A edges do not touch capture A and that pin B ignores its polarity bit. A lockstep reference model catches any off-by-one in synchronizer latency, because captured values would then differ by one count.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;
    localparam int NUM_CH = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_CAPA = 2'd2;
    localparam logic [ADDR_W-1:0] A_CAPB = 2'd3;

    typedef struct packed {
        logic en_b;
        logic en_a;
        logic pol_b;
        logic pol_a;
        logic ev_mode;
    } ctrl_t;

    typedef struct packed {
        logic uflow;
        logic pend_b;
        logic pend_a;
    } flag_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int FLAG_W = $bits(flag_t);

    function automatic logic pick_edge(input logic rise, input logic fall, input logic falling_sel);
        return falling_sel ? fall : rise;
    endfunction
endpackage

// File: rtl/dct_edge_sync.sv
`timescale 1ns/1ps
module dct_edge_sync #(
    parameter int STAGES = dct_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int MSB = STAGES - 1;

    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin};
            prev_q <= sh_q[MSB];
        end
    end

    assign rise = sh_q[MSB] & ~prev_q;
    assign fall = ~sh_q[MSB] & prev_q;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);  // R3
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);  // R3
endmodule

// File: rtl/dct_down_counter.sv
`timescale 1ns/1ps
module dct_down_counter #(
    parameter int WIDTH = dct_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [WIDTH-1:0] cnt,
    output logic             uflow
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '1;
        else if (step) cnt <= cnt - 1'b1;
    end

    assign uflow = step && (cnt == '0);

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        step |=> cnt == $past(cnt) - 1'b1);  // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));  // R7
    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        uflow |=> cnt == '1);  // R2
endmodule

// File: rtl/dct_capture_reg.sv
`timescale 1ns/1ps
module dct_capture_reg #(
    parameter int WIDTH = dct_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end

    AST_CAP_TAKE: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(din));  // R3
    AST_CAP_KEEP: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));  // R3
endmodule

// File: rtl/dual_capture_timer.sv
`timescale 1ns/1ps
module dual_capture_timer
    import dct_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW-1:0]     rd_data,
    output logic              irq_a,
    output logic              irq_b
);
    ctrl_t ctrl_q;
    flag_t flags_q, set_v, clr_v;

    logic [CW-1:0]     cnt;
    logic              uflow;
    logic              step;
    logic [NUM_CH-1:0] pin_vec, rise, fall, pol, trig, load;
    logic [CW-1:0]     cap [NUM_CH];

    assign pin_vec = {pin_b, pin_a};
    assign pol     = {ctrl_q.pol_b, ctrl_q.pol_a};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .pin  (pin_vec[ch]),
            .rise (rise[ch]),
            .fall (fall[ch])
        );
        assign trig[ch] = pick_edge(rise[ch], fall[ch], pol[ch]);
        assign load[ch] = !ctrl_q.ev_mode && trig[ch];
        dct_capture_reg #(.WIDTH(CW)) u_cap (
            .clk  (clk),
            .rst  (rst),
            .load (load[ch]),
            .din  (cnt),
            .q    (cap[ch])
        );
    end

    assign step = ctrl_q.ev_mode ? rise[0] : 1'b1;

    dct_down_counter #(.WIDTH(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .cnt   (cnt),
        .uflow (uflow)
    );

    always_comb begin
        set_v.pend_a = load[0];
        set_v.pend_b = ctrl_q.ev_mode ? rise[1] : trig[1];
        set_v.uflow  = uflow;
        clr_v        = '0;
        if (wr_en && wr_addr == A_FLAG) clr_v = ~wr_data[FLAG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data);
            flags_q <= (flags_q & ~clr_v) | set_v;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = CW'(ctrl_q);
            A_FLAG:  rd_data = CW'(flags_q);
            A_CAPA:  rd_data = cap[0];
            default: rd_data = cap[1];
        endcase
    end

    assign irq_a = ctrl_q.en_a && (flags_q.pend_a || flags_q.uflow);
    assign irq_b = ctrl_q.en_b && flags_q.pend_b;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags_q.pend_a && !(wr_en && wr_addr == A_FLAG && !wr_data[0]) |=> flags_q.pend_a);  // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        set_v.pend_b |=> flags_q.pend_b);  // R5
    AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        uflow |=> flags_q.uflow);  // R2
    AST_EVENT_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.ev_mode |=> $stable(cap[0]) && $stable(cap[1]));  // R7
endmodule

// File: tb/test_dual_capture_timer.sv
`timescale 1ns/1ps
module test_dual_capture_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_a = 1'b0, pin_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [4:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq_a, irq_b;

    int n_chk = 0;
    int n_err = 0;
    logic lock_on = 1'b0;

    always #2 clk = ~clk;

    dual_capture_timer i_dual_capture_timer (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_a(irq_a), .irq_b(irq_b)
    );

    // Reference model built from the requirements
    logic [15:0] m_cnt, m_capa, m_capb;
    logic [4:0]  m_ctrl;
    logic [2:0]  m_flags;
    logic [1:0]  m_s1, m_s2, m_p;
    logic [1:0]  t_r, t_f, t_t;
    logic        t_ha, t_hb, t_step, t_uf;
    logic [2:0]  t_clr;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 16'hFFFF; m_capa <= '0; m_capb <= '0;
            m_ctrl <= '0; m_flags <= '0; m_s1 <= '0; m_s2 <= '0; m_p <= '0;
        end else begin
            t_r = m_s2 & ~m_p;
            t_f = ~m_s2 & m_p;
            t_t[0] = m_ctrl[1] ? t_f[0] : t_r[0];
            t_t[1] = m_ctrl[2] ? t_f[1] : t_r[1];
            t_ha   = !m_ctrl[0] && t_t[0];
            t_hb   = m_ctrl[0] ? t_r[1] : t_t[1];
            t_step = m_ctrl[0] ? t_r[0] : 1'b1;
            t_uf   = t_step && (m_cnt == 16'h0000);
            if (t_step) m_cnt <= m_cnt - 16'd1;
            if (t_ha) m_capa <= m_cnt;
            if (!m_ctrl[0] && t_t[1]) m_capb <= m_cnt;
            t_clr = (wr_en && wr_addr == 2'd1) ? ~wr_data[2:0] : 3'b000;
            m_flags <= (m_flags & ~t_clr) | {t_uf, t_hb, t_ha};
            if (wr_en && wr_addr == 2'd0) m_ctrl <= wr_data;
            m_s1 <= {pin_b, pin_a};
            m_s2 <= m_s1;
            m_p  <= m_s2;
        end
    end

    function automatic logic [15:0] model_reg(input logic [1:0] a);
        case (a)
            2'd0:    return {11'b0, m_ctrl};
            2'd1:    return {13'b0, m_flags};
            2'd2:    return m_capa;
            default: return m_capb;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // R6: interrupt lines follow the model every cycle
    always @(negedge clk) begin
        if (lock_on && !rst) begin
            chk("R6 irq_a", {15'b0, irq_a}, {15'b0, m_ctrl[3] && (m_flags[0] || m_flags[2])});
            chk("R6 irq_b", {15'b0, irq_b}, {15'b0, m_ctrl[4] && m_flags[1]});
        end
    end

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic cmp_reg(input logic [1:0] a, input string tag);
        logic [15:0] v;
        rd(a, v);
        chk(tag, v, model_reg(a));
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_pin(input int which, input logic v, input int hold);
        @(negedge clk);
        if (which == 0) pin_a = v; else pin_b = v;
        repeat (hold) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v, saved;
        void'($urandom(32'h5EED_C0DE));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        lock_on = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset register", v, 16'h0000);
        end
        chk("R1 irq after reset", {14'b0, irq_a, irq_b}, 16'h0000);

        // Basic capture, both enables on, rising edges
        wr(2'd0, 5'b11000);
        cmp_reg(2'd0, "R9 control readback");
        set_pin(0, 1'b1, 4);
        cmp_reg(2'd2, "R1 R3 capture A value");
        rd(2'd1, v);
        chk("R5 pend_a set", v & 16'h3, 16'h1);
        chk("R6 irq_a on capture", {15'b0, irq_a}, 16'h1);
        set_pin(1, 1'b1, 4);
        cmp_reg(2'd3, "R3 capture B value");
        wr(2'd1, 3'b110);
        rd(2'd1, v);
        chk("R5 write 0 clears only its bit", v & 16'h3, 16'h2);
        chk("R6 irq_a drops", {15'b0, irq_a}, 16'h0);

        // R4 polarity, independently per pin
        wr(2'd0, 5'b11010);
        wr(2'd1, 3'b000);
        set_pin(0, 1'b0, 4);
        rd(2'd1, v);
        chk("R4 pin A falling selected", v & 16'h3, 16'h1);
        cmp_reg(2'd2, "R4 capture A on falling");
        rd(2'd2, saved);
        wr(2'd1, 3'b000);
        set_pin(0, 1'b1, 4);
        set_pin(1, 1'b0, 4);
        rd(2'd1, v);
        chk("R4 unselected edges ignored", v & 16'h3, 16'h0);
        rd(2'd2, v);
        chk("R4 capture A kept", v, saved);
        set_pin(1, 1'b1, 4);
        rd(2'd1, v);
        chk("R4 pin B still rising", v & 16'h3, 16'h2);

        // R5 set wins over a same-cycle clear
        wr(2'd0, 5'b11000);
        set_pin(0, 1'b0, 4);
        wr(2'd1, 3'b000);
        @(negedge clk) pin_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 5'b00000;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd1, v);
        chk("R5 set wins over clear", v & 16'h3, 16'h1);

        // R7 event mode on pin A
        wr(2'd0, 5'b11001);
        wr(2'd1, 3'b000);
        rd(2'd2, saved);
        for (int k = 0; k < 3; k++) begin
            set_pin(0, 1'b0, 3);
            set_pin(0, 1'b1, 3);
        end
        rd(2'd1, v);
        chk("R7 no pend_a in event mode", v & 16'h1, 16'h0);
        rd(2'd2, v);
        chk("R7 no capture A in event mode", v, saved);

        // R8 pin B as rising-edge interrupt, polarity ignored
        wr(2'd0, 5'b11101);
        set_pin(1, 1'b0, 4);
        wr(2'd1, 3'b000);
        rd(2'd3, saved);
        set_pin(1, 1'b1, 4);
        rd(2'd1, v);
        chk("R8 pend_b on rising edge", v & 16'h2, 16'h2);
        rd(2'd3, v);
        chk("R8 no capture B in event mode", v, saved);
        chk("R8 irq_b", {15'b0, irq_b}, 16'h1);

        // Back to capture: counter value proves event stepping
        wr(2'd0, 5'b11000);
        set_pin(0, 1'b0, 3);
        set_pin(0, 1'b1, 4);
        cmp_reg(2'd2, "R7 counter stepped by events only");

        // Random phase
        for (int it = 0; it < 2000; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1, 2: set_pin(0, ~pin_a, int'($urandom_range(0, 4)));
                3, 4, 5: set_pin(1, ~pin_b, int'($urandom_range(0, 4)));
                6:       wr(2'd0, 5'($urandom()));
                7:       wr(2'd1, 3'($urandom()));
                default: repeat (int'($urandom_range(1, 6))) @(negedge clk);
            endcase
            begin
                logic [1:0] a;
                a = 2'($urandom());
                case (a)
                    2'd0:    cmp_reg(a, "R9 random control read");
                    2'd1:    cmp_reg(a, "R5 random flags");
                    default: cmp_reg(a, "R3 random capture");
                endcase
            end
        end

        // R2 full wrap in capture mode
        wr(2'd0, 5'b01000);
        wr(2'd1, 3'b000);
        repeat (65540) @(negedge clk);
        rd(2'd1, v);
        chk("R2 wrap flag set", v & 16'h4, 16'h4);
        chk("R2 wrap drives irq_a", {15'b0, irq_a}, 16'h1);
        set_pin(0, ~pin_a, 4);
        set_pin(0, ~pin_a, 4);
        cmp_reg(2'd2, "R2 counter after wrap");
        wr(2'd1, 3'b011);
        rd(2'd1, v);
        chk("R2 wrap flag cleared", v & 16'h4, 16'h0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule